// File: doc/BRIEF.md
# Multi-Mode Serial Port Controller

This block is a full-duplex serial port with four framing modes, all timed by its own baud-rate generator. Mode 0 is a synchronous shifter: the block drives a shift clock on `txd` and moves eight data bits, least significant first, over the bidirectional data line (`rxd_in` / `rxd_out` / `rxd_oe`). Mode 1 sends and receives ten-bit asynchronous frames. Modes 2 and 3 add a ninth data bit for multiprocessor addressing. They differ only in receive qualification: mode 2 accepts a frame only when its ninth bit is set, and mode 3 accepts every frame.

Software reaches the block through a small byte-wide write port. Address 0 holds the control byte: mode in bits 1:0, receive enable in bit 2, and the ninth transmit bit in bit 3. Address 1 is the baud register, which is loaded low byte first and then high byte. Address 2 is the transmit buffer. The status byte is always visible and holds RI in bit 0, TI in bit 1, the received ninth bit in bit 2 and a framing-error flag in bit 3. A one-cycle read strobe clears both interrupt flags. The last accepted byte appears on `rx_data`.

Top module: `serport_top`

## Requirements
- R1: After reset, `txd` is 1, `rxd_oe` is 0, the status byte and `rx_data` are 0 and both interrupt outputs are low. `txd` is 1 whenever no transfer is active.
- R2: The baud value is assembled from two writes to address 1: the first write is the low byte and the second is the high byte. Its low 15 bits N give one baud tick every N+1 enabled source cycles. An asynchronous bit lasts 8 ticks, and each half of a mode-0 shift clock lasts 1 tick.
- R3: Bit 15 of the baud value selects the source. A 1 selects `xtal_en` and a 0 selects `ext_en`. With the selected source idle, a started frame does not advance.
- R4: In mode 1 a write to address 2 sends a 0 start bit, the eight data bits LSB first, and a 1 stop bit on `txd`. At the end of the frame, TI (status bit 1) is set and `ti_irq` pulses once.
- R5: A write to the transmit buffer while a frame is being sent is ignored.
- R6: In modes 2 and 3 the frame carries a ninth data bit after the eighth, and its value is control bit 3.
- R7: With receive enable (control bit 2) set in mode 1, a frame on `rxd_in` is decoded by a majority vote of three samples near mid-bit. The decoded frame loads `rx_data`, sets RI (status bit 0) and pulses `ri_irq`. With receive enable clear, frames are ignored.
- R8: A low pulse on `rxd_in` shorter than half a bit is rejected as a false start. It sets no flag, and the next valid frame is still received correctly.
- R9: An accepted frame whose stop bit reads 0 sets the framing-error flag (status bit 3). The next accepted frame with a good stop bit clears it.
- R10: In mode 2, a frame whose ninth bit is 0 changes neither RI, `rx_data` nor the status. A frame whose ninth bit is 1 is accepted, and the ninth bit is stored in status bit 2.
- R11: In mode 3 every frame is accepted, and its ninth bit is stored in status bit 2.
- R12: Pulsing `stat_rd` clears RI and TI on the next edge, unless a new event sets a flag in that same cycle.
- R13: In mode 0 a transmit-buffer write produces exactly eight low-then-high shift-clock pulses on `txd`. `rxd_oe` is 1 during the transfer, `rxd_out` carries each data bit LSB first and is valid at each rising clock edge, and TI is set at the end.
- R14: In mode 0, writing the control byte with receive enable set starts a receive. `rxd_in` is sampled at each of the eight rising shift-clock edges, LSB first. At the end the byte is loaded into `rx_data` and RI is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Write address: 0 control, 1 baud, 2 transmit buffer |
| reg_wdata | input | 8 | Write data |
| stat_rd | input | 1 | Status read strobe; clears RI and TI |
| stat_q | output | 8 | Status byte {0000, FE, RB8, TI, RI} |
| rx_data | output | 8 | Last accepted received byte |
| xtal_en | input | 1 | Crystal-derived source enable |
| ext_en | input | 1 | External-clock source enable |
| txd | output | 1 | Serial transmit line, or shift clock in mode 0 |
| rxd_in | input | 1 | Serial receive line / mode-0 data input |
| rxd_out | output | 1 | Mode-0 transmit data |
| rxd_oe | output | 1 | Output enable for the data line |
| ti_irq | output | 1 | One-cycle pulse when TI is set |
| ri_irq | output | 1 | One-cycle pulse when RI is set |

## Verification
The hardest situation to produce from the ports is a mode-0 receive. The data line must change in step with a shift clock that the block itself generates, so a fixed-time stimulus cannot line up with it. The bench watches `txd` and presents each new bit on the falling shift-clock edge, which leaves the value stable across the synchronizer before the rising edge that samples it. Rejection in mode 2 and false-start filtering are also hard to see, because nothing at the ports changes. Each such stimulus is therefore followed by a valid frame, to show that the receiver stayed aligned and that `rx_data` kept its earlier value.

// File: rtl/serport_pkg.sv
package serport_pkg;
  localparam int BYTE_W = 8;
  localparam int BAUD_W = 16;
  localparam int DIV_W  = BAUD_W - 1;
  localparam int OVS_W  = 3;
  localparam int ADDR_W = 2;

  localparam logic [ADDR_W-1:0] A_CTRL = 2'd0;
  localparam logic [ADDR_W-1:0] A_BAUD = 2'd1;
  localparam logic [ADDR_W-1:0] A_TXB  = 2'd2;

  typedef enum logic [1:0] {
    M_SHIFT = 2'd0,
    M_ASYNC8 = 2'd1,
    M_ASYNC9Q = 2'd2,
    M_ASYNC9 = 2'd3
  } sp_mode_e;
endpackage

// File: rtl/serport_baud.sv
module serport_baud
  import serport_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [BYTE_W-1:0] wdata,
  input  logic             xtal_en,
  input  logic             ext_en,
  output logic             tick
);
  logic [BYTE_W-1:0] lo_q, lo_d;
  logic              hi_q, hi_d;
  logic [BAUD_W-1:0] baud_q, baud_d;
  logic [DIV_W-1:0]  cnt_q, cnt_d;
  logic              tick_q, tick_d;
  logic              src_en;

  assign src_en = baud_q[BAUD_W-1] ? xtal_en : ext_en;

  always_comb begin
    lo_d   = lo_q;
    hi_d   = hi_q;
    baud_d = baud_q;
    cnt_d  = cnt_q;
    tick_d = 1'b0;
    if (wr_en) begin
      if (!hi_q) begin
        lo_d = wdata;
        hi_d = 1'b1;
      end else begin
        baud_d = {wdata, lo_q};
        hi_d   = 1'b0;
      end
    end
    if (src_en) begin
      if (cnt_q == '0) begin
        cnt_d  = baud_q[DIV_W-1:0];
        tick_d = 1'b1;
      end else begin
        cnt_d = cnt_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q   <= '0;
      hi_q   <= 1'b0;
      baud_q <= {1'b1, {DIV_W{1'b0}}};
      cnt_q  <= '0;
      tick_q <= 1'b0;
    end else begin
      lo_q   <= lo_d;
      hi_q   <= hi_d;
      baud_q <= baud_d;
      cnt_q  <= cnt_d;
      tick_q <= tick_d;
    end
  end

  assign tick = tick_q;
endmodule

// File: rtl/serport_atx.sv
module serport_atx
  import serport_pkg::*;
#(
  parameter int OVS = OVS_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              start,
  input  logic              nine,
  input  logic              tb8,
  input  logic [BYTE_W-1:0] data,
  output logic              txd,
  output logic              busy,
  output logic              done
);
  localparam int FR_W = BYTE_W + 3;
  localparam int CNT_W = $clog2(FR_W);

  logic              busy_q, busy_d;
  logic [FR_W-1:0]   sh_q, sh_d;
  logic [OVS-1:0]    sub_q, sub_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              done_q, done_d;
  logic [CNT_W-1:0]  last;

  assign last = nine ? CNT_W'(FR_W - 1) : CNT_W'(FR_W - 2);

  always_comb begin
    busy_d = busy_q;
    sh_d   = sh_q;
    sub_d  = sub_q;
    cnt_d  = cnt_q;
    done_d = 1'b0;
    if (!busy_q) begin
      if (start) begin
        busy_d = 1'b1;
        sh_d   = {1'b1, (nine ? tb8 : 1'b1), data, 1'b0};
        sub_d  = '0;
        cnt_d  = '0;
      end
    end else if (tick) begin
      sub_d = sub_q + 1'b1;
      if (sub_q == {OVS{1'b1}}) begin
        sh_d = {1'b1, sh_q[FR_W-1:1]};
        if (cnt_q == last) begin
          busy_d = 1'b0;
          done_d = 1'b1;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      sh_q   <= '1;
      sub_q  <= '0;
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else begin
      busy_q <= busy_d;
      sh_q   <= sh_d;
      sub_q  <= sub_d;
      cnt_q  <= cnt_d;
      done_q <= done_d;
    end
  end

  assign txd  = busy_q ? sh_q[0] : 1'b1;
  assign busy = busy_q;
  assign done = done_q;
endmodule

// File: rtl/serport_arx.sv
module serport_arx
  import serport_pkg::*;
#(
  parameter int OVS = OVS_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              en,
  input  logic              nine,
  input  logic              din,
  output logic              done,
  output logic [BYTE_W-1:0] data,
  output logic              bit8,
  output logic              stop_ok
);
  localparam int SH_W  = BYTE_W + 1;
  localparam int IDX_W = $clog2(BYTE_W + 3);
  localparam logic [OVS-1:0] SMP_B = OVS'(2 ** (OVS - 1));
  localparam logic [OVS-1:0] SMP_A = SMP_B - 1'b1;
  localparam logic [OVS-1:0] SMP_C = SMP_B + 1'b1;

  logic              act_q, act_d;
  logic [OVS-1:0]    sub_q, sub_d;
  logic [IDX_W-1:0]  idx_q, idx_d;
  logic              sa_q, sa_d, sb_q, sb_d;
  logic [SH_W-1:0]   sh_q, sh_d;
  logic              done_q, done_d;
  logic              stop_q, stop_d;
  logic              vote;
  logic [IDX_W-1:0]  last;

  assign vote = (sa_q & sb_q) | (sa_q & din) | (sb_q & din);
  assign last = nine ? IDX_W'(BYTE_W + 2) : IDX_W'(BYTE_W + 1);

  always_comb begin
    act_d  = act_q;
    sub_d  = sub_q;
    idx_d  = idx_q;
    sa_d   = sa_q;
    sb_d   = sb_q;
    sh_d   = sh_q;
    done_d = 1'b0;
    stop_d = stop_q;
    if (!act_q) begin
      if (tick && en && !din) begin
        act_d = 1'b1;
        sub_d = OVS'(1);
        idx_d = '0;
      end
    end else if (tick) begin
      sub_d = sub_q + 1'b1;
      if (sub_q == SMP_A) sa_d = din;
      if (sub_q == SMP_B) sb_d = din;
      if (sub_q == SMP_C) begin
        if (idx_q == '0) begin
          if (vote) act_d = 1'b0;
          else      idx_d = idx_q + 1'b1;
        end else if (idx_q == last) begin
          act_d  = 1'b0;
          done_d = 1'b1;
          stop_d = vote;
        end else begin
          sh_d  = {vote, sh_q[SH_W-1:1]};
          idx_d = idx_q + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      sub_q  <= '0;
      idx_q  <= '0;
      sa_q   <= 1'b1;
      sb_q   <= 1'b1;
      sh_q   <= '0;
      done_q <= 1'b0;
      stop_q <= 1'b1;
    end else begin
      act_q  <= act_d;
      sub_q  <= sub_d;
      idx_q  <= idx_d;
      sa_q   <= sa_d;
      sb_q   <= sb_d;
      sh_q   <= sh_d;
      done_q <= done_d;
      stop_q <= stop_d;
    end
  end

  assign done    = done_q;
  assign data    = nine ? sh_q[BYTE_W-1:0] : sh_q[SH_W-1:1];
  assign bit8    = nine & sh_q[SH_W-1];
  assign stop_ok = stop_q;
endmodule

// File: rtl/serport_shift.sv
module serport_shift
  import serport_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              start_tx,
  input  logic              start_rx,
  input  logic [BYTE_W-1:0] data,
  input  logic              din,
  output logic              sclk,
  output logic              dout,
  output logic              doe,
  output logic              busy,
  output logic              tx_done,
  output logic              rx_done,
  output logic [BYTE_W-1:0] rx_byte
);
  localparam int CNT_W = $clog2(BYTE_W);

  logic              busy_q, busy_d;
  logic              dir_q, dir_d;
  logic              ph_q, ph_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [BYTE_W-1:0] sh_q, sh_d;
  logic              txd_q, txd_d;
  logic              rxd_q, rxd_d;

  always_comb begin
    busy_d = busy_q;
    dir_d  = dir_q;
    ph_d   = ph_q;
    cnt_d  = cnt_q;
    sh_d   = sh_q;
    txd_d  = 1'b0;
    rxd_d  = 1'b0;
    if (!busy_q) begin
      if (start_tx || start_rx) begin
        busy_d = 1'b1;
        dir_d  = start_tx;
        ph_d   = 1'b0;
        cnt_d  = '0;
        if (start_tx) sh_d = data;
      end
    end else if (tick) begin
      if (!ph_q) begin
        ph_d = 1'b1;
        if (!dir_q) sh_d = {din, sh_q[BYTE_W-1:1]};
      end else begin
        ph_d = 1'b0;
        if (dir_q) sh_d = {1'b0, sh_q[BYTE_W-1:1]};
        if (cnt_q == CNT_W'(BYTE_W - 1)) begin
          busy_d = 1'b0;
          txd_d  = dir_q;
          rxd_d  = !dir_q;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      dir_q  <= 1'b0;
      ph_q   <= 1'b0;
      cnt_q  <= '0;
      sh_q   <= '0;
      txd_q  <= 1'b0;
      rxd_q  <= 1'b0;
    end else begin
      busy_q <= busy_d;
      dir_q  <= dir_d;
      ph_q   <= ph_d;
      cnt_q  <= cnt_d;
      sh_q   <= sh_d;
      txd_q  <= txd_d;
      rxd_q  <= rxd_d;
    end
  end

  assign sclk    = busy_q ? ph_q : 1'b1;
  assign dout    = sh_q[0];
  assign doe     = busy_q & dir_q;
  assign busy    = busy_q;
  assign tx_done = txd_q;
  assign rx_done = rxd_q;
  assign rx_byte = sh_q;
endmodule

// File: rtl/serport_top.sv
module serport_top
  import serport_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [BYTE_W-1:0] reg_wdata,
  input  logic              stat_rd,
  output logic [BYTE_W-1:0] stat_q,
  output logic [BYTE_W-1:0] rx_data,
  input  logic              xtal_en,
  input  logic              ext_en,
  output logic              txd,
  input  logic              rxd_in,
  output logic              rxd_out,
  output logic              rxd_oe,
  output logic              ti_irq,
  output logic              ri_irq
);
  sp_mode_e          mode_q, mode_d;
  logic              ren_q, ren_d, tb8_q, tb8_d;
  logic              ri_q, ri_d, ti_q, ti_d, rb8_q, rb8_d, fe_q, fe_d;
  logic [BYTE_W-1:0] rxb_q, rxb_d;
  logic              tiirq_q, riirq_q;
  logic              rs1_q, rs2_q;

  logic wr_ctrl, wr_baud, wr_txb, is_shift, nine;
  logic tick;
  logic atx_txd, atx_busy, atx_done;
  logic arx_done, arx_b8, arx_stop, arx_ok;
  logic [BYTE_W-1:0] arx_data;
  logic sh_sclk, sh_dout, sh_doe, sync_busy, sh_txdone, sh_rxdone;
  logic [BYTE_W-1:0] sh_rxbyte;
  logic set_ti, set_ri;

  assign wr_ctrl  = reg_we && (reg_addr == A_CTRL);
  assign wr_baud  = reg_we && (reg_addr == A_BAUD);
  assign wr_txb   = reg_we && (reg_addr == A_TXB);
  assign is_shift = (mode_q == M_SHIFT);
  assign nine     = mode_q[1];

  serport_baud u_baud (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_baud), .wdata(reg_wdata),
    .xtal_en(xtal_en), .ext_en(ext_en), .tick(tick)
  );

  serport_atx #(.OVS(OVS_W)) u_atx (
    .clk(clk), .rst_n(rst_n), .tick(tick), .start(wr_txb && !is_shift),
    .nine(nine), .tb8(tb8_q), .data(reg_wdata),
    .txd(atx_txd), .busy(atx_busy), .done(atx_done)
  );

  serport_arx #(.OVS(OVS_W)) u_arx (
    .clk(clk), .rst_n(rst_n), .tick(tick), .en(ren_q && !is_shift),
    .nine(nine), .din(rs2_q), .done(arx_done), .data(arx_data),
    .bit8(arx_b8), .stop_ok(arx_stop)
  );

  serport_shift u_shift (
    .clk(clk), .rst_n(rst_n), .tick(tick),
    .start_tx(wr_txb && is_shift),
    .start_rx(wr_ctrl && (reg_wdata[1:0] == M_SHIFT) && reg_wdata[2]),
    .data(reg_wdata), .din(rs2_q),
    .sclk(sh_sclk), .dout(sh_dout), .doe(sh_doe), .busy(sync_busy),
    .tx_done(sh_txdone), .rx_done(sh_rxdone), .rx_byte(sh_rxbyte)
  );

  assign arx_ok = arx_done && ((mode_q != M_ASYNC9Q) || arx_b8);
  assign set_ti = atx_done | sh_txdone;
  assign set_ri = arx_ok | sh_rxdone;

  always_comb begin
    mode_d = mode_q;
    ren_d  = ren_q;
    tb8_d  = tb8_q;
    if (wr_ctrl) begin
      mode_d = sp_mode_e'(reg_wdata[1:0]);
      ren_d  = reg_wdata[2];
      tb8_d  = reg_wdata[3];
    end
    ri_d  = set_ri ? 1'b1 : (stat_rd ? 1'b0 : ri_q);
    ti_d  = set_ti ? 1'b1 : (stat_rd ? 1'b0 : ti_q);
    rb8_d = arx_ok ? arx_b8 : rb8_q;
    fe_d  = arx_ok ? !arx_stop : fe_q;
    rxb_d = rxb_q;
    if (sh_rxdone)   rxb_d = sh_rxbyte;
    else if (arx_ok) rxb_d = arx_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= M_SHIFT;
      ren_q   <= 1'b0;
      tb8_q   <= 1'b0;
      ri_q    <= 1'b0;
      ti_q    <= 1'b0;
      rb8_q   <= 1'b0;
      fe_q    <= 1'b0;
      rxb_q   <= '0;
      tiirq_q <= 1'b0;
      riirq_q <= 1'b0;
      rs1_q   <= 1'b1;
      rs2_q   <= 1'b1;
    end else begin
      mode_q  <= mode_d;
      ren_q   <= ren_d;
      tb8_q   <= tb8_d;
      ri_q    <= ri_d;
      ti_q    <= ti_d;
      rb8_q   <= rb8_d;
      fe_q    <= fe_d;
      rxb_q   <= rxb_d;
      tiirq_q <= set_ti;
      riirq_q <= set_ri;
      rs1_q   <= rxd_in;
      rs2_q   <= rs1_q;
    end
  end

  assign stat_q  = {4'b0000, fe_q, rb8_q, ti_q, ri_q};
  assign rx_data = rxb_q;
  assign txd     = sh_sclk & atx_txd;
  assign rxd_out = sh_dout;
  assign rxd_oe  = sh_doe;
  assign ti_irq  = tiirq_q;
  assign ri_irq  = riirq_q;
endmodule

// File: rtl/serport_chk.sv
module serport_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       txd,
  input logic       ti_irq,
  input logic       ri_irq,
  input logic       stat_rd,
  input logic [7:0] stat_q,
  input logic       rxd_oe,
  input logic       atx_busy,
  input logic       sync_busy
);
  AST_TXD_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (!atx_busy && !sync_busy) |-> txd); // R1
  AST_TI_IRQ_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    ti_irq |-> stat_q[1]); // R4
  AST_TI_IRQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    ti_irq |=> !ti_irq); // R4
  AST_RI_IRQ_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    ri_irq |-> stat_q[0]); // R7
  AST_RD_CLEARS_RI: assert property (@(posedge clk) disable iff (!rst_n)
    stat_rd |=> (!stat_q[0] || ri_irq)); // R12
  AST_RD_CLEARS_TI: assert property (@(posedge clk) disable iff (!rst_n)
    stat_rd |=> (!stat_q[1] || ti_irq)); // R12
  AST_OE_IN_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
    rxd_oe |-> sync_busy); // R13
endmodule

bind serport_top serport_chk i_chk (
  .clk(clk), .rst_n(rst_n), .txd(txd), .ti_irq(ti_irq), .ri_irq(ri_irq),
  .stat_rd(stat_rd), .stat_q(stat_q), .rxd_oe(rxd_oe),
  .atx_busy(atx_busy), .sync_busy(sync_busy)
);

// File: tb/test_serport_top.sv
module test_serport_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_we = 1'b0;
  logic [1:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic       stat_rd = 1'b0;
  logic [7:0] stat_q, rx_data;
  logic       xtal_en = 1'b1;
  logic       ext_en = 1'b0;
  logic       txd, rxd_out, rxd_oe, ti_irq, ri_irq;
  logic       rxd_drv = 1'b1;

  int checks = 0;
  int errors = 0;
  int ti_cnt = 0;
  int ri_cnt = 0;

  always #2 clk = ~clk;

  serport_top i_serport_top (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .stat_rd(stat_rd), .stat_q(stat_q),
    .rx_data(rx_data), .xtal_en(xtal_en), .ext_en(ext_en), .txd(txd),
    .rxd_in(rxd_drv), .rxd_out(rxd_out), .rxd_oe(rxd_oe),
    .ti_irq(ti_irq), .ri_irq(ri_irq)
  );

  always @(negedge clk) begin
    if (rst_n && ti_irq) ti_cnt <= ti_cnt + 1;
    if (rst_n && ri_irq) ri_cnt <= ri_cnt + 1;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd_stat(output logic [7:0] v);
    @(negedge clk);
    v = stat_q;
    stat_rd = 1'b1;
    @(negedge clk);
    stat_rd = 1'b0;
  endtask

  task automatic set_baud(input logic [15:0] b);
    wr(2'd1, b[7:0]);
    wr(2'd1, b[15:8]);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic cap_async(input int nd, input int bc, output logic [8:0] bits, output logic stp);
    int to;
    to = 0;
    bits = '0;
    while (txd === 1'b1 && to < 5000) begin @(negedge clk); to++; end
    repeat (bc / 2) @(negedge clk);
    for (int i = 0; i < nd; i++) begin
      repeat (bc) @(negedge clk);
      bits[i] = txd;
    end
    repeat (bc) @(negedge clk);
    stp = txd;
  endtask

  task automatic send_async(input logic [8:0] d, input int nd, input logic stp, input int bc);
    rxd_drv = 1'b0;
    repeat (bc) @(negedge clk);
    for (int i = 0; i < nd; i++) begin
      rxd_drv = d[i];
      repeat (bc) @(negedge clk);
    end
    rxd_drv = stp;
    repeat (bc) @(negedge clk);
    rxd_drv = 1'b1;
    repeat (6) @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R1 txd idle", txd, 1'b1);
    chk("R1 rxd_oe", rxd_oe, 1'b0);
    chk("R1 status", stat_q, 8'h00);
    chk("R1 rx_data", rx_data, 8'h00);
    chk("R1 irq pulses", ti_cnt + ri_cnt, 0);
  endtask

  task automatic t_baud_tx();
    logic [8:0] b; logic s; logic [7:0] st; int t0;
    set_baud(16'h8003);
    wr(2'd0, 8'h01);
    t0 = ti_cnt;
    wr(2'd2, 8'hA5);
    cap_async(8, 32, b, s);
    chk("R2 R4 data at 32-clk bit", b[7:0], 8'hA5);
    chk("R4 stop bit", s, 1'b1);
    idle(40);
    chk("R4 ti_irq pulse", ti_cnt - t0, 1);
    rd_stat(st);
    chk("R4 TI flag", st[1], 1'b1);
  endtask

  task automatic t_busy_ignore();
    logic [8:0] b; logic s; int t0; logic low_seen;
    set_baud(16'h8001);
    t0 = ti_cnt;
    wr(2'd2, 8'h5C);
    fork
      cap_async(8, 16, b, s);
      begin idle(40); wr(2'd2, 8'h3C); end
    join
    chk("R5 first frame kept", b[7:0], 8'h5C);
    low_seen = 1'b0;
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      if (!txd) low_seen = 1'b1;
    end
    chk("R5 no second frame", low_seen, 1'b0);
    chk("R5 single TI pulse", ti_cnt - t0, 1);
  endtask

  task automatic t_nine_tx();
    logic [8:0] b; logic s;
    wr(2'd0, 8'h0B);
    wr(2'd2, 8'h5A);
    cap_async(9, 16, b, s);
    chk("R6 mode3 frame with ninth=1", b, 9'h15A);
    chk("R6 stop", s, 1'b1);
    idle(20);
    wr(2'd0, 8'h02);
    wr(2'd2, 8'hFF);
    cap_async(9, 16, b, s);
    chk("R6 mode2 frame with ninth=0", b, 9'h0FF);
    idle(20);
  endtask

  task automatic t_ext_clock();
    logic [8:0] b; logic s; logic moved; int t0;
    wr(2'd0, 8'h01);
    set_baud(16'h0001);
    t0 = ti_cnt;
    wr(2'd2, 8'h96);
    moved = 1'b0;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (txd) moved = 1'b1;
    end
    chk("R3 frame frozen without ext source", moved, 1'b0);
    chk("R3 no TI while frozen", ti_cnt - t0, 0);
    ext_en = 1'b1;
    cap_async(8, 16, b, s);
    chk("R3 frame on ext source", b[7:0], 8'h96);
    idle(20);
    ext_en = 1'b0;
    set_baud(16'h8001);
  endtask

  task automatic t_rx_mode1();
    logic [7:0] st; int r0;
    wr(2'd0, 8'h05);
    r0 = ri_cnt;
    send_async(9'h03C, 8, 1'b1, 16);
    chk("R7 rx_data", rx_data, 8'h3C);
    chk("R7 ri_irq pulse", ri_cnt - r0, 1);
    rd_stat(st);
    chk("R7 RI set, FE clear", {st[3], st[0]}, 2'b01);
    @(negedge clk);
    chk("R12 read cleared RI and TI", stat_q[1:0], 2'b00);
    wr(2'd0, 8'h01);
    r0 = ri_cnt;
    send_async(9'h077, 8, 1'b1, 16);
    chk("R7 receive disabled: data kept", rx_data, 8'h3C);
    chk("R7 receive disabled: no RI", {stat_q[0], 8'(ri_cnt - r0)}, 9'h000);
  endtask

  task automatic t_false_start();
    int r0;
    wr(2'd0, 8'h05);
    r0 = ri_cnt;
    @(negedge clk); rxd_drv = 1'b0;
    idle(2); rxd_drv = 1'b1;
    idle(200);
    chk("R8 glitch sets nothing", {stat_q[0], 8'(ri_cnt - r0)}, 9'h000);
    chk("R8 data kept", rx_data, 8'h3C);
    send_async(9'h081, 8, 1'b1, 16);
    chk("R8 next frame aligned", rx_data, 8'h81);
  endtask

  task automatic t_fe();
    logic [7:0] st;
    send_async(9'h0E7, 8, 1'b0, 16);
    idle(40);
    chk("R9 bad stop sets FE", stat_q[3], 1'b1);
    chk("R9 bad-stop data", rx_data, 8'hE7);
    send_async(9'h011, 8, 1'b1, 16);
    chk("R9 good frame clears FE", stat_q[3], 1'b0);
    rd_stat(st);
  endtask

  task automatic t_mode2();
    int r0;
    wr(2'd0, 8'h06);
    r0 = ri_cnt;
    send_async(9'h042, 9, 1'b1, 16);
    chk("R10 ninth=0 no RI", {stat_q[0], 8'(ri_cnt - r0)}, 9'h000);
    chk("R10 ninth=0 data kept", rx_data, 8'h11);
    send_async(9'h199, 9, 1'b1, 16);
    chk("R10 ninth=1 accepted", rx_data, 8'h99);
    chk("R10 RI and RB8", {stat_q[2], stat_q[0]}, 2'b11);
    chk("R10 one pulse", ri_cnt - r0, 1);
  endtask

  task automatic t_mode3();
    logic [7:0] st; int r0;
    rd_stat(st);
    wr(2'd0, 8'h07);
    r0 = ri_cnt;
    send_async(9'h024, 9, 1'b1, 16);
    chk("R11 ninth=0 accepted", rx_data, 8'h24);
    chk("R11 RI set, RB8 clear", {stat_q[2], stat_q[0]}, 2'b01);
    chk("R11 pulse", ri_cnt - r0, 1);
  endtask

  task automatic t_shift_tx();
    logic [7:0] st; logic [7:0] got; logic prev; int n; logic oe_bad; int t0;
    rd_stat(st);
    set_baud(16'h8007);
    wr(2'd0, 8'h00);
    t0 = ti_cnt;
    wr(2'd2, 8'hB4);
    got = '0; n = 0; oe_bad = 1'b0;
    prev = txd;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (!prev && txd) begin
        if (n < 8) got[n] = rxd_out;
        if (!rxd_oe) oe_bad = 1'b1;
        n++;
      end
      prev = txd;
    end
    chk("R13 shift data", got, 8'hB4);
    chk("R13 pulse count", n, 8);
    chk("R13 output enable", oe_bad, 1'b0);
    chk("R13 TI", {stat_q[1], 8'(ti_cnt - t0)}, 9'h101);
  endtask

  task automatic t_shift_rx();
    logic [7:0] st; logic [7:0] pat; logic prev; int n; int r0;
    rd_stat(st);
    pat = 8'h6D;
    r0 = ri_cnt;
    rxd_drv = pat[0];
    wr(2'd0, 8'h04);
    n = 0;
    prev = txd;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (!prev && txd) n++;
      if (prev && !txd && n < 8) rxd_drv = pat[n];
      prev = txd;
    end
    rxd_drv = 1'b1;
    chk("R14 clock pulses", n, 8);
    chk("R14 received byte", rx_data, 8'h6D);
    chk("R14 RI", {stat_q[0], 8'(ri_cnt - r0)}, 9'h101);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(3);
    t_reset();
    t_baud_tx();
    t_busy_ignore();
    t_nine_tx();
    t_ext_clock();
    t_rx_mode1();
    t_false_start();
    t_fe();
    t_mode2();
    t_mode3();
    t_shift_tx();
    t_shift_rx();
    idle(10);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule